// File: doc/BRIEF.md
# Word-Interleaved Four-Bank Line Refill Memory

This block is both the controller and a behavioural model of a main memory made of four banks, each one word wide. Word addresses are interleaved across the banks, so the four words of a cache line sit in four different banks. A cache asks for a whole line by giving its line address. The controller sends the address once, taking four cycles. All four banks then fetch their words at the same time, taking 24 cycles. The words come back one at a time over a shared one-word bus, taking four cycles each. A refill therefore takes 44 cycles.

The `INTERLEAVE` parameter can be set to 0 to get a plain sequential memory for comparison. In that mode each word has its own address phase, access phase and transfer phase, so a line takes 128 cycles. In both modes a cache sees the same interface. It raises a request strobe while the block is idle. It collects one word on each data-valid pulse. It treats the pulse that carries the done flag as the end of the refill. The bank contents are a fixed function of the word address. Writes are not part of this block.

Top module: `interleaved_mem`

## Requirements
- R1: While reset is asserted and in the first cycle after reset is released, `busy`, `wordValid` and `lineDone` are all low.
- R2: At a clock edge where `reqGo` is high and `busy` is low, the request is accepted. `reqLine` is captured and `busy` is high from the next cycle on. Cycle t=1 is the first cycle after the accepting edge.
- R3: While `busy` is high, `reqGo` and `reqLine` have no effect. The words of the accepted line come back unchanged and with the same timing. A request that was held through the refill is not queued: `busy` falls after the refill.
- R4: With `INTERLEAVE`=1, word k is presented in cycle t = 32 + 4k. `busy` stays high for exactly 44 cycles.
- R5: With `INTERLEAVE`=0, word k is presented in cycle t = 32(k+1). `busy` stays high for exactly 128 cycles.
- R6: The words come back in the order k = 0, 1, 2, 3. `wordIdx` gives k while `wordValid` is high. Word k lives at word address {line, k}, so bank k (address bits [1:0] = k) supplies it.
- R7: The data word at the 16-bit zero-extended word address A is {A XOR 16'hA5C3, A}, with A in the low half.
- R8: `wordValid` is high for exactly one cycle per word and is never high in two consecutive cycles. There are four pulses per refill, all while `busy` is high.
- R9: `lineDone` is high in the same cycle as the pulse for word 3 and in no other cycle. `busy` is low in the cycle that follows.
- R10: A new request driven in the first cycle with `busy` low is accepted at once, so refills can run back to back with one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| reqGo | input | 1 | Line refill request strobe |
| reqLine | input | WADDR_W-2 | Line address of the request |
| busy | output | 1 | A refill is in progress; requests are refused |
| wordValid | output | 1 | One-cycle pulse: `wordData` holds word `wordIdx` |
| wordIdx | output | 2 | Index of the word in the line, which is also its bank |
| wordData | output | 32 | Returned data word |
| lineDone | output | 1 | Asserted together with the last word of the line |

## Verification
The bound checker watches the properties that hold in every cycle. It checks that a request is accepted when the block is idle and that `busy` holds until the done pulse. It checks that data-valid pulses never touch and always fall on the transfer-slot grid of the selected mode. It also checks the word order, that done coincides with word 3, and the exact refill length, which it measures with a counter. Only the bench's scenarios can show that each returned word carries the right data for its own address, and that a request changed or held while busy does not corrupt the line or queue a second refill. The bench sweeps every line address in interleaved mode, runs a set of lines through the sequential mode, and chains refills back to back.

// File: rtl/imem_pkg.sv
package imem_pkg;

  // Fixed organisation: four one-word banks selected by word address bits [1:0].
  localparam int NUM_BANKS = 4;
  localparam int BANK_BITS = $clog2(NUM_BANKS);
  localparam int DATA_W    = 32;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ACCESS,
    PH_XFER
  } phase_t;

  // Strobes passed from the sequencer to the datapath.
  typedef struct packed {
    logic                 loadLine;
    logic [NUM_BANKS-1:0] bankLatch;
    logic [BANK_BITS-1:0] xferSel;
    logic                 wordStrobe;
    logic                 lastWord;
  } strobe_t;

  // Modelled content of the banks: a fixed function of the word address.
  function automatic logic [DATA_W-1:0] cellValue(input logic [15:0] wordAddr);
    return {wordAddr ^ 16'hA5C3, wordAddr};
  endfunction

endpackage

// File: rtl/imem_ctrl.sv
module imem_ctrl
  import imem_pkg::*;
#(
  parameter int ADDR_CYC   = 4,
  parameter int ACCESS_CYC = 24,
  parameter int XFER_CYC   = 4,
  parameter bit INTERLEAVE = 1'b1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqGo,
  output logic    busy,
  output strobe_t strb
);

  localparam int CNT_W = $clog2(ADDR_CYC + ACCESS_CYC + XFER_CYC + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST   = CNT_W'(ADDR_CYC - 1);
  localparam logic [CNT_W-1:0] ACCESS_LAST = CNT_W'(ACCESS_CYC - 1);
  localparam logic [CNT_W-1:0] XFER_LAST   = CNT_W'(XFER_CYC - 1);
  localparam logic [BANK_BITS-1:0] FINAL_WORD = BANK_BITS'(NUM_BANKS - 1);

  phase_t               phase;
  logic [CNT_W-1:0]     phaseCnt;
  logic [BANK_BITS-1:0] wordNum;

  logic accessEnd;
  logic xferEnd;

  assign accessEnd = (phase == PH_ACCESS) && (phaseCnt == ACCESS_LAST);
  assign xferEnd   = (phase == PH_XFER)   && (phaseCnt == XFER_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      phaseCnt <= '0;
      wordNum  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (reqGo) begin
            phase    <= PH_ADDR;
            phaseCnt <= '0;
            wordNum  <= '0;
          end
        end
        PH_ADDR: begin
          if (phaseCnt == ADDR_LAST) begin
            phase    <= PH_ACCESS;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        PH_ACCESS: begin
          if (accessEnd) begin
            phase    <= PH_XFER;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        PH_XFER: begin
          if (xferEnd) begin
            phaseCnt <= '0;
            if (wordNum == FINAL_WORD) begin
              phase <= PH_IDLE;
            end else begin
              wordNum <= wordNum + 1'b1;
              // Interleaved: the next word is already in its bank.
              // Sequential: the next word needs its own address and access.
              phase   <= INTERLEAVE ? PH_XFER : PH_ADDR;
            end
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  generate
    if (INTERLEAVE) begin : g_parallel
      always_comb strb.bankLatch = accessEnd ? {NUM_BANKS{1'b1}} : '0;
    end else begin : g_serial
      always_comb begin
        strb.bankLatch = '0;
        if (accessEnd) strb.bankLatch[wordNum] = 1'b1;
      end
    end
  endgenerate

  assign strb.loadLine   = (phase == PH_IDLE) && reqGo;
  assign strb.xferSel    = wordNum;
  assign strb.wordStrobe = xferEnd;
  assign strb.lastWord   = xferEnd && (wordNum == FINAL_WORD);
  assign busy            = (phase != PH_IDLE);

endmodule

// File: rtl/imem_datapath.sv
module imem_datapath
  import imem_pkg::*;
#(
  parameter int WADDR_W = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WADDR_W-3:0]   reqLine,
  input  strobe_t              strb,
  output logic [DATA_W-1:0]    wordData
);

  localparam int LINE_W = WADDR_W - BANK_BITS;

  logic [LINE_W-1:0] lineReg;
  logic [DATA_W-1:0] bankWord [NUM_BANKS];

  always_ff @(posedge clk) begin
    if (!rstN)              lineReg <= '0;
    else if (strb.loadLine) lineReg <= reqLine;
  end

  // Each bank holds the row addressed by the line; bank i supplies word {line, i}.
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN)                  bankWord[i] <= '0;
      else if (strb.bankLatch[i]) bankWord[i] <= cellValue(16'({lineReg, BANK_BITS'(i)}));
    end
  end

  // Shared one-word return bus.
  assign wordData = bankWord[strb.xferSel];

endmodule

// File: rtl/interleaved_mem.sv
module interleaved_mem
  import imem_pkg::*;
#(
  parameter int WADDR_W    = 12,
  parameter int ADDR_CYC   = 4,
  parameter int ACCESS_CYC = 24,
  parameter int XFER_CYC   = 4,
  parameter bit INTERLEAVE = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqGo,
  input  logic [WADDR_W-3:0] reqLine,
  output logic               busy,
  output logic               wordValid,
  output logic [1:0]         wordIdx,
  output logic [31:0]        wordData,
  output logic               lineDone
);

  strobe_t strb;

  imem_ctrl #(
    .ADDR_CYC  (ADDR_CYC),
    .ACCESS_CYC(ACCESS_CYC),
    .XFER_CYC  (XFER_CYC),
    .INTERLEAVE(INTERLEAVE)
  ) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .reqGo(reqGo),
    .busy (busy),
    .strb (strb)
  );

  imem_datapath #(
    .WADDR_W(WADDR_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .reqLine (reqLine),
    .strb    (strb),
    .wordData(wordData)
  );

  assign wordValid = strb.wordStrobe;
  assign wordIdx   = strb.xferSel;
  assign lineDone  = strb.lastWord;

endmodule

// File: rtl/imem_check.sv
module imem_check #(
  parameter int ADDR_CYC   = 4,
  parameter int ACCESS_CYC = 24,
  parameter int XFER_CYC   = 4,
  parameter bit INTERLEAVE = 1'b1
) (
  input logic       clk,
  input logic       rstN,
  input logic       reqGo,
  input logic       busy,
  input logic       wordValid,
  input logic [1:0] wordIdx,
  input logic       lineDone
);

  localparam int FIRST_SLOT = ADDR_CYC + ACCESS_CYC + XFER_CYC;
  localparam int SLOT_GAP   = INTERLEAVE ? XFER_CYC : FIRST_SLOT;
  localparam int TOTAL      = FIRST_SLOT + 3 * SLOT_GAP;
  localparam int CNT_W      = $clog2(TOTAL + 2);

  logic [CNT_W-1:0] busyCnt;   // equals t-1 during cycle t of a refill
  logic [1:0]       nextIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
      nextIdx <= '0;
    end else begin
      busyCnt <= busy ? busyCnt + 1'b1 : '0;
      if (!busy)          nextIdx <= '0;
      else if (wordValid) nextIdx <= nextIdx + 1'b1;
    end
  end

  a_r2_accept_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqGo) |=> busy);

  a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lineDone) |=> busy);

  a_r4_r5_word_slot: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> ((int'(busyCnt) + 1 >= FIRST_SLOT) &&
                   (((int'(busyCnt) + 1 - FIRST_SLOT) % SLOT_GAP) == 0)));

  a_r4_r5_length: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |-> (int'(busyCnt) == TOTAL - 1));

  a_r6_word_order: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (wordIdx == nextIdx));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  a_r8_valid_in_refill: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> busy);

  a_r9_done_last_word: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |-> (wordValid && wordIdx == 2'd3));

  a_r9_done_ends: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |=> !busy);

endmodule

bind interleaved_mem imem_check #(
  .ADDR_CYC  (ADDR_CYC),
  .ACCESS_CYC(ACCESS_CYC),
  .XFER_CYC  (XFER_CYC),
  .INTERLEAVE(INTERLEAVE)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqGo    (reqGo),
  .busy     (busy),
  .wordValid(wordValid),
  .wordIdx  (wordIdx),
  .lineDone (lineDone)
);

// File: tb/interleaved_mem_test.sv
module interleaved_mem_test;

  localparam int CLK_PERIOD = 10;
  localparam int WADDR_W    = 12;
  localparam int LINE_W     = WADDR_W - 2;
  localparam int FIRST_SLOT = 4 + 24 + 4;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqGoA = 1'b0, reqGoB = 1'b0;
  logic [LINE_W-1:0] reqLineA = '0, reqLineB = '0;
  logic busyA, busyB, validA, validB, doneA, doneB;
  logic [1:0]  idxA, idxB;
  logic [31:0] dataA, dataB;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  interleaved_mem #(.WADDR_W(WADDR_W), .INTERLEAVE(1'b1)) uut (
    .clk(clk), .rstN(rstN), .reqGo(reqGoA), .reqLine(reqLineA),
    .busy(busyA), .wordValid(validA), .wordIdx(idxA), .wordData(dataA),
    .lineDone(doneA)
  );

  interleaved_mem #(.WADDR_W(WADDR_W), .INTERLEAVE(1'b0)) uutSeq (
    .clk(clk), .rstN(rstN), .reqGo(reqGoB), .reqLine(reqLineB),
    .busy(busyB), .wordValid(validB), .wordIdx(idxB), .wordData(dataB),
    .lineDone(doneB)
  );

  function automatic logic [31:0] expWord(input logic [LINE_W-1:0] line, input int k);
    logic [15:0] a;
    a = 16'({line, 2'(k)});
    return {a ^ 16'hA5C3, a};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic setReq(input bit seq, input logic go, input logic [LINE_W-1:0] line);
    if (seq) begin reqGoB = go; reqLineB = line; end
    else     begin reqGoA = go; reqLineA = line; end
  endtask

  // Starts at a negedge with the block idle; ends at the negedge of cycle total+1.
  task automatic refill(input bit seq, input logic [LINE_W-1:0] line, input bit hold);
    int total, gap;
    logic b, v, d;
    logic [1:0] ix;
    logic [31:0] dat;
    string rq;
    gap   = seq ? FIRST_SLOT : 4;
    total = FIRST_SLOT + 3 * gap;
    rq    = seq ? "R5" : "R4";
    setReq(seq, 1'b1, line);
    @(posedge clk);
    for (int t = 1; t <= total + 1; t++) begin
      @(negedge clk);
      b   = seq ? busyB  : busyA;
      v   = seq ? validB : validA;
      d   = seq ? doneB  : doneA;
      ix  = seq ? idxB   : idxA;
      dat = seq ? dataB  : dataA;
      if (t == 1) begin
        // R2 and R10: accepted at the first idle edge
        check(b == 1'b1, "R2", "busy after accept", 32'(b), 32'd1);
        // R3: a changed or held request while busy must not matter
        if (hold) setReq(seq, 1'b1, ~line);
        else      setReq(seq, 1'b0, line);
      end
      if (t == total) setReq(seq, 1'b0, line);
      if (t <= total) begin
        if (!b) check(1'b0, rq, "busy length", 32'(t), 32'(total));
      end else begin
        check(b == 1'b0, hold ? "R3" : rq, "busy after refill", 32'(b), 32'd0);
      end
      if ((t >= FIRST_SLOT) && (t <= total) && ((t - FIRST_SLOT) % gap == 0)) begin
        int k;
        k = (t - FIRST_SLOT) / gap;
        check(v == 1'b1, rq, "wordValid in slot", 32'(t), 32'(t));
        check(ix == 2'(k), "R6", "word index", 32'(ix), 32'(k));
        check(dat == expWord(line, k), hold ? "R3" : "R7", "word data", dat, expWord(line, k));
        check(d == (k == 3), "R9", "lineDone with word", 32'(d), 32'(k == 3));
      end else begin
        if (v) check(1'b0, "R8", "stray wordValid", 32'(t), 32'd0);
        if (d) check(1'b0, "R9", "stray lineDone", 32'(t), 32'd0);
      end
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stimulus
    repeat (2) @(negedge clk);
    // R1: outputs quiet under reset, even with a request pending
    reqGoA = 1'b1;
    @(negedge clk);
    check(!busyA && !validA && !doneA, "R1", "outputs in reset",
          {29'd0, busyA, validA, doneA}, 32'd0);
    check(!busyB && !validB && !doneB, "R1", "seq outputs in reset",
          {29'd0, busyB, validB, doneB}, 32'd0);
    reqGoA = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check(!busyA && !validA && !doneA, "R1", "outputs after reset",
          {29'd0, busyA, validA, doneA}, 32'd0);

    // R4, R6, R7, R10: every line address back to back in interleaved mode
    for (int ln = 0; ln < (1 << LINE_W); ln++) begin
      refill(1'b0, LINE_W'(ln), (ln % 8) == 3);
    end

    // R5: sequential comparison mode, corners and a spread of lines
    for (int n = 0; n < 16; n++) begin
      int ln;
      ln = (n == 15) ? (1 << LINE_W) - 1 : n * 37;
      refill(1'b1, LINE_W'(ln), n == 5);
    end

    // R3: a request still held from a finished refill must start nothing new
    repeat (3) @(negedge clk);
    check(!busyA && !busyB, "R3", "idle after refills", {30'd0, busyA, busyB}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule